// File: doc/BRIEF.md
# Comma-to-Comma Latency Meter

This block times the path between two points of a serial data link. It counts, in clock cycles, from a comma seen at a chosen start point to a comma seen at a chosen stop point. Each end has two possible sources. The start is either the four-lane low-speed transmit side or the two 10-bit halves of the high-speed receive word. The stop is either the four-lane low-speed receive side or the two halves of the high-speed transmit word. Comma detection happens upstream: the block receives one comma-found pulse per lane or word half.

The result is read through two 16-bit registers. The status register carries which positions saw the start and stop commas, a ready flag and count bits 19:16. The count register carries count bits 15:0. Software reads the status register first, which captures the low count bits. It then reads the count register. That second read wipes the measurement and rearms the meter for the next start comma.

Top module: `lat_meter`

## Requirements
- R1: After reset both registers read 0x0000.
- R2: With `start_sel`=0 a start comma is any bit of `lstx_comma` (bit n is lane n). With `start_sel`=1 it is any bit of `hsrx_comma` (bit 0 is data[9:0], bit 1 is data[19:10]), and `lstx_comma` is ignored.
- R3: With `stop_sel`=0 a stop comma is any bit of `lsrx_comma`. With `stop_sel`=1 it is any bit of `hstx_comma` (same bit meaning as in R2), and `lsrx_comma` is ignored.
- R4: The count equals the number of clock edges from the cycle holding the start comma to the cycle holding the stop comma, so a gap of N idle cycles gives N+1. The ready flag (status bit 4) is 1 from then on.
- R5: The count saturates at `CNT_CEIL`, which defaults to 20'hFFFFF.
- R6: While ready is 0, the count fields of both registers read as zero.
- R7: Status bits 15:12 record the start positions seen and bits 11:8 the stop positions seen. In word mode bits 1:0 of a field are used and bits 3:2 read 0. Status bits 7:5 always read 0.
- R8: Status bits 3:0 show count bits 19:16 once ready is 1.
- R9: A read of the count register (`rd_addr`=1 with `rd_en`) clears the count, the ready flag, both comma fields and the captured low bits. The meter then waits for a new start comma.
- R10: The count register returns the low 16 count bits captured at the last status register read (`rd_addr`=0 with `rd_en`).
- R11: After a measurement completes, later start and stop commas change nothing until the clear of R9.
- R12: A clear in the same cycle as a start comma wins, and the start comma is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_sel | input | 1 | 0: low-speed TX lanes start, 1: high-speed RX halves start |
| stop_sel | input | 1 | 0: low-speed RX lanes stop, 1: high-speed TX halves stop |
| lstx_comma | input | 4 | Comma pulse per low-speed transmit lane |
| hsrx_comma | input | 2 | Comma pulse per high-speed receive word half |
| lsrx_comma | input | 4 | Comma pulse per low-speed receive lane |
| hstx_comma | input | 2 | Comma pulse per high-speed transmit word half |
| rd_en | input | 1 | Read strobe; triggers capture or clear side effect |
| rd_addr | input | 1 | 0: status register, 1: count register |
| rd_data | output | 16 | Read data for `rd_addr` |

## Verification
The bench tries the meter with lane-to-lane and half-to-half paths on different positions. This separates correct source selection from any cross-talk, and a comma on an unselected source must leave the status fields untouched. Short gaps check the off-by-one of the count. A gap longer than a reduced ceiling checks saturation. Early reads check that the count is hidden until the measurement completes. Extra commas after completion, and a clear that coincides with a start comma, check the freeze and the priority between the two. A behavioural model, compared every clock, covers every cycle between these checks.

// File: rtl/lat_pkg.sv
package lat_pkg;
  localparam int CNT_W  = 20;
  localparam int FLAG_W = 4;
  localparam int REG_W  = 16;

  typedef enum logic [1:0] {ST_ARMED, ST_RUN, ST_DONE} lat_state_e;

  // one saturating step of the latency counter
  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] v,
                                                input logic [CNT_W-1:0] ceil);
    return (v >= ceil) ? ceil : v + 1'b1;
  endfunction

  // status register image: start flags, stop flags, gap, ready, count top
  function automatic logic [REG_W-1:0] pack_status(input logic [FLAG_W-1:0] sflags,
                                                   input logic [FLAG_W-1:0] pflags,
                                                   input logic              ready,
                                                   input logic [CNT_W-1:0]  cnt);
    logic [CNT_W-REG_W-1:0] top;
    top = ready ? cnt[CNT_W-1:REG_W] : '0;
    return {sflags, pflags, 3'b000, ready, top};
  endfunction
endpackage

// File: rtl/lat_src_sel.sv
module lat_src_sel
  import lat_pkg::*;
#(
  parameter int HALVES = 2
) (
  input  logic              sel,
  input  logic [FLAG_W-1:0] lane,
  input  logic [HALVES-1:0] half,
  output logic [FLAG_W-1:0] vec,
  output logic              hit
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_pos
    if (i < HALVES) begin : g_shared
      assign vec[i] = sel ? half[i] : lane[i];
    end else begin : g_lane_only
      assign vec[i] = sel ? 1'b0 : lane[i];
    end
  end
  assign hit = |vec;
endmodule

// File: rtl/lat_core.sv
module lat_core
  import lat_pkg::*;
#(
  parameter logic [CNT_W-1:0] CNT_CEIL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] start_vec,
  input  logic              start_hit,
  input  logic [FLAG_W-1:0] stop_vec,
  input  logic              stop_hit,
  input  logic              clr,
  output logic [CNT_W-1:0]  cnt,
  output logic              ready,
  output logic [FLAG_W-1:0] sflags,
  output logic [FLAG_W-1:0] pflags
);
  lat_state_e st;
  logic arm_evt, stop_evt;

  assign arm_evt  = (st == ST_ARMED) && start_hit && !clr;
  assign stop_evt = (st == ST_RUN)   && stop_hit  && !clr;
  assign ready    = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_ARMED;
      cnt    <= '0;
      sflags <= '0;
      pflags <= '0;
    end else if (clr) begin
      st     <= ST_ARMED;
      cnt    <= '0;
      sflags <= '0;
      pflags <= '0;
    end else begin
      unique case (st)
        ST_ARMED: if (arm_evt) begin
          st     <= ST_RUN;
          cnt    <= '0;
          sflags <= start_vec;
        end
        ST_RUN: begin
          cnt <= sat_step(cnt, CNT_CEIL);
          if (stop_evt) begin
            st     <= ST_DONE;
            pflags <= stop_vec;
          end
        end
        default: ;
      endcase
    end
  end

  AST_CNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_CEIL);                                                    // R5
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !clr && !$isunknown(cnt)) |=> (ready && $stable(cnt) && $stable(pflags))); // R11
  AST_CLR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ready && cnt == '0 && sflags == '0 && pflags == '0));       // R9
  AST_STOP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> ready);                                                 // R4
  AST_CLR_BEATS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && start_hit) |=> (sflags == '0));                              // R12
endmodule

// File: rtl/lat_regs.sv
module lat_regs
  import lat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ready,
  input  logic [FLAG_W-1:0] sflags,
  input  logic [FLAG_W-1:0] pflags,
  output logic              clr,
  output logic [REG_W-1:0]  rd_data
);
  logic [REG_W-1:0] hold_lo;
  logic             snap;

  assign snap = rd_en && !rd_addr;
  assign clr  = rd_en &&  rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_lo <= '0;
    else if (clr)  hold_lo <= '0;
    else if (snap) hold_lo <= ready ? cnt[REG_W-1:0] : '0;
  end

  assign rd_data = rd_addr ? hold_lo : pack_status(sflags, pflags, ready, cnt);

  AST_HIDDEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !rd_addr) |-> (rd_data[3:0] == 4'h0));                    // R6
  AST_SNAP_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (snap && !ready) |=> (hold_lo == '0));                               // R6
endmodule

// File: rtl/lat_meter.sv
module lat_meter
  import lat_pkg::*;
#(
  parameter logic [19:0] CNT_CEIL = 20'hFFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_sel,
  input  logic        stop_sel,
  input  logic [3:0]  lstx_comma,
  input  logic [1:0]  hsrx_comma,
  input  logic [3:0]  lsrx_comma,
  input  logic [1:0]  hstx_comma,
  input  logic        rd_en,
  input  logic        rd_addr,
  output logic [15:0] rd_data
);
  logic [FLAG_W-1:0] start_vec, stop_vec, sflags, pflags;
  logic              start_hit, stop_hit, clr, ready;
  logic [CNT_W-1:0]  cnt;

  lat_src_sel #(.HALVES(2)) u_start (
    .sel(start_sel), .lane(lstx_comma), .half(hsrx_comma),
    .vec(start_vec), .hit(start_hit));

  lat_src_sel #(.HALVES(2)) u_stop (
    .sel(stop_sel), .lane(lsrx_comma), .half(hstx_comma),
    .vec(stop_vec), .hit(stop_hit));

  lat_core #(.CNT_CEIL(CNT_CEIL)) u_core (
    .clk(clk), .rst_n(rst_n),
    .start_vec(start_vec), .start_hit(start_hit),
    .stop_vec(stop_vec), .stop_hit(stop_hit),
    .clr(clr), .cnt(cnt), .ready(ready),
    .sflags(sflags), .pflags(pflags));

  lat_regs u_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .cnt(cnt), .ready(ready), .sflags(sflags), .pflags(pflags),
    .clr(clr), .rd_data(rd_data));

  AST_STATUS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_addr) |-> (rd_data[7:5] == 3'b000));                            // R7
endmodule

// File: tb/lat_meter_test.sv
`timescale 1ns/1ps
module lat_meter_test;
  localparam int CEIL = 300;

  logic        clk = 0, rst_n = 0;
  logic        start_sel = 0, stop_sel = 0;
  logic [3:0]  lstx_comma = 0, lsrx_comma = 0;
  logic [1:0]  hsrx_comma = 0, hstx_comma = 0;
  logic        rd_en = 0, rd_addr = 0;
  logic [15:0] rd_data;

  int total = 0, bad = 0;

  lat_meter #(.CNT_CEIL(20'(CEIL))) uut (
    .clk(clk), .rst_n(rst_n), .start_sel(start_sel), .stop_sel(stop_sel),
    .lstx_comma(lstx_comma), .hsrx_comma(hsrx_comma),
    .lsrx_comma(lsrx_comma), .hstx_comma(hstx_comma),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  always #10 clk = ~clk;

  // behavioural reference: phase 0 waiting, 1 timing, 2 finished
  int phase = 0, m_cnt = 0, m_hold = 0;
  logic [3:0] m_sf = 0, m_pf = 0;

  function automatic logic [15:0] model_out(input logic addr);
    int shown;
    shown = (phase == 2) ? m_cnt : 0;
    if (addr) return 16'(m_hold);
    return {m_sf, m_pf, 3'b000, (phase == 2), 4'(shown >> 16)};
  endfunction

  always @(posedge clk) begin
    logic [3:0] sv, pv;
    sv = start_sel ? {2'b00, hsrx_comma} : lstx_comma;
    pv = stop_sel  ? {2'b00, hstx_comma} : lsrx_comma;
    if (rst_n) begin
      if (rd_en && rd_addr) begin
        phase = 0; m_cnt = 0; m_sf = 0; m_pf = 0; m_hold = 0;
      end else begin
        if (rd_en && !rd_addr) m_hold = (phase == 2) ? (m_cnt % 65536) : 0;
        if (phase == 0 && sv != 0) begin
          phase = 1; m_cnt = 0; m_sf = sv;
        end else if (phase == 1) begin
          m_cnt = (m_cnt + 1 > CEIL) ? CEIL : m_cnt + 1;
          if (pv != 0) begin phase = 2; m_pf = pv; end
        end
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) check("R4/R8 per-cycle model", rd_data, model_out(rd_addr));

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic peek(input logic addr, input string req, input logic [15:0] exp);
    rd_addr = addr; #1; check(req, rd_data, exp);
  endtask

  task automatic rd(input logic addr);
    rd_addr = addr; rd_en = 1; tick(1); rd_en = 0;
  endtask

  task automatic pulse_start(input logic [3:0] l, input logic [1:0] h);
    lstx_comma = l; hsrx_comma = h; tick(1); lstx_comma = 0; hsrx_comma = 0;
  endtask

  task automatic pulse_stop(input logic [3:0] l, input logic [1:0] h);
    lsrx_comma = l; hstx_comma = h; tick(1); lsrx_comma = 0; hstx_comma = 0;
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(2); rst_n = 1; tick(1);
    // R1 reset
    peek(0, "R1 status after reset", 16'h0000);
    peek(1, "R1 count after reset", 16'h0000);

    // lane to lane, gap 6 -> count 7 (R2, R3, R4)
    start_sel = 0; stop_sel = 0;
    pulse_start(4'b0100, 2'b11);        // halves ignored in lane mode (R2)
    tick(3);
    peek(0, "R6 count hidden while timing", 16'h4000);
    rd(0);                                 // capture while not ready
    peek(1, "R6 captured low bits hidden", 16'h0000);
    tick(2);
    pulse_stop(4'b0010, 2'b11);          // halves ignored (R3)
    peek(0, "R4 R7 R8 lane result", 16'h4210 | 16'h0007 & 16'h0000);
    peek(0, "R8 status layout", 16'h4210);
    rd(0);
    peek(1, "R4 R10 low count 7", 16'h0007);
    // R11 frozen: further commas change nothing
    pulse_start(4'b1000, 2'b00);
    pulse_stop(4'b0001, 2'b00);
    tick(3);
    peek(0, "R11 frozen status", 16'h4210);
    peek(1, "R11 frozen low", 16'h0007);
    rd(1);
    peek(0, "R9 status cleared", 16'h0000);
    peek(1, "R9 count cleared", 16'h0000);

    // word to word (R2, R3, R7)
    start_sel = 1; stop_sel = 1;
    lstx_comma = 4'b1000; tick(2); lstx_comma = 0;
    peek(0, "R2 lane start ignored in word mode", 16'h0000);
    pulse_start(4'b0000, 2'b10);
    tick(1);
    lsrx_comma = 4'b1111; tick(1); lsrx_comma = 0;
    peek(0, "R3 lane stop ignored in word mode", 16'h2000);
    pulse_stop(4'b0000, 2'b01);
    peek(0, "R7 word flags, upper bits zero", 16'h2110);
    rd(0);
    peek(1, "R4 word count", 16'h0003);
    rd(1);

    // saturation at ceiling (R5, R8 upper field zero since ceiling < 2^16)
    start_sel = 0; stop_sel = 0;
    pulse_start(4'b0001, 2'b00);
    tick(400);
    pulse_stop(4'b1000, 2'b00);
    rd(0);
    peek(1, "R5 saturated count", 16'(CEIL));
    peek(0, "R5 status after saturation", 16'h1810);
    rd(1);

    // clear coincides with start (R12)
    rd_addr = 1; rd_en = 1; lstx_comma = 4'b0010; tick(1);
    rd_en = 0; lstx_comma = 0;
    peek(0, "R12 start dropped on clear", 16'h0000);
    pulse_stop(4'b0001, 2'b00);
    peek(0, "R12 stop without start ignored", 16'h0000);
    // new measurement still works after rearm (R9)
    pulse_start(4'b0010, 2'b00);
    pulse_stop(4'b0100, 2'b00);
    rd(0);
    peek(1, "R9 rearmed count 1", 16'h0001);
    peek(0, "R9 rearmed status", 16'h2410);
    rd(1);
    tick(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule